// File: doc/BRIEF.md
# Real-Time Calendar Counter with Freeze Handshake

This block keeps wall-clock time for a chip. A slow oscillator strobe (one pulse per 32.768 kHz period, synchronous to the system clock) drives a sub-second prescaler. Each prescaler wrap yields a one-second tick, and that tick steps a chain of second, minute, hour, day, month and year counters. The day counter follows the month length and adds February 29 in leap years.

Software takes a coherent snapshot, or loads a new time, by freezing the calendar. It raises a freeze request and waits for the freeze-granted status. While the freeze is granted the calendar fields hold still and can be written, but the prescaler keeps counting. A second that elapses during the freeze is owed and is paid back exactly once after the request is dropped. Loading the seconds field restarts the prescaler and forgives any owed second.

A periodic event (every second or every minute) and an external alarm event each set their own sticky status flag. Both flags drive a single interrupt line. Software clears a flag by writing 0 to its bit, and a 1 in a flag bit leaves that flag alone.

Top module: `rtc_calendar_hold`

## Requirements
- R1: After reset the fields read second 0, minute 0, hour 0, day 1, month 1, year 0, and hold_ack, per_flag, alm_flag and irq are all 0.
- R2: When not frozen, the seconds field advances once for every 2^PRESC_W osc_tick pulses, on the clock edge that samples the pulse that takes the prescaler from its maximum back to 0.
- R3: Seconds and minutes roll from 59 to 0 and carry. Hours roll from 23 to 0 and carry. Month rolls from 12 to 1 and carries. Year rolls from 99 to 0.
- R4: The day rolls to 1 after day 31 in months 1, 3, 5, 7, 8, 10 and 12, after day 30 in months 4, 6, 9 and 11, and after day 28 in February, or after day 29 in February when the year is a multiple of 4.
- R5: hold_ack rises on the first clock edge that samples osc_tick while hold_req is 1. While hold_ack is 1 the calendar does not advance. hold_ack falls on the first clock edge at which hold_req is 0.
- R6: A write (wr_en with wr_field 0 = second, 1 = minute, 2 = hour, 3 = day, 4 = month, 5 = year, data in wr_data) loads the field only while hold_ack is 1. A write while hold_ack is 0, or with wr_field 6 or 7, changes nothing.
- R7: If the prescaler wraps one or more times while hold_ack is 1, the seconds counter advances exactly once, on the second clock edge after hold_req goes to 0.
- R8: A seconds write during a freeze clears the prescaler and cancels any owed advance.
- R9: per_flag is set by a calendar advance: every advance when per_sel is 0, and only an advance that rolls seconds from 59 to 0 when per_sel is 1. Field writes never set it.
- R10: alarm_evt sets alm_flag. A flag_wr_en write clears per_flag where flag_wr_data bit 0 is 0 and clears alm_flag where bit 1 is 0. A 1 in a bit leaves that flag unchanged.
- R11: irq is 1 exactly when per_flag or alm_flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle strobe per slow-oscillator period |
| hold_req | input | 1 | Freeze request for the calendar fields |
| wr_en | input | 1 | Calendar field write strobe |
| wr_field | input | 3 | Field code for the write |
| wr_data | input | 7 | Value written to the field |
| flag_wr_en | input | 1 | Status flag write strobe |
| flag_wr_data | input | 2 | Bit 0 periodic, bit 1 alarm; 0 clears, 1 keeps |
| per_sel | input | 1 | Periodic event rate: 0 each second, 1 each minute |
| alarm_evt | input | 1 | Alarm match strobe from the compare logic |
| sec | output | 6 | Seconds, 0 to 59 |
| min | output | 6 | Minutes, 0 to 59 |
| hour | output | 5 | Hours, 0 to 23 |
| day | output | 5 | Day of month, 1 to 31 |
| month | output | 4 | Month, 1 to 12 |
| year | output | 7 | Year, 0 to 99 |
| hold_ack | output | 1 | Freeze granted |
| per_flag | output | 1 | Periodic event status |
| alm_flag | output | 1 | Alarm event status |
| irq | output | 1 | Shared interrupt |

## Verification
The bench builds the block with PRESC_W = 2, so one second costs only four oscillator pulses. At that size every month end of five chosen years, including leap and century-wrap years, can be swept with a full roll from 23:59:59. The short second also makes prescaler wraps inside a freeze easy to force, so the owed-second replay, the cancel on a seconds write and both periodic rates are all exercised within a few thousand cycles. LEAP_EN stays at its default of 1.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   localparam int CAL_DATA_W = 7;

   typedef enum logic [2:0] {
      FLD_SEC   = 3'd0,
      FLD_MIN   = 3'd1,
      FLD_HOUR  = 3'd2,
      FLD_DAY   = 3'd3,
      FLD_MONTH = 3'd4,
      FLD_YEAR  = 3'd5
   } cal_field_e;

   // Last day of a month; leap selects the 29-day February.
   function automatic logic [4:0] month_len(input logic [3:0] mon, input logic leap);
      case (mon)
         4'd2:                       month_len = leap ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11:    month_len = 5'd30;
         default:                    month_len = 5'd31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int PRESC_W = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_tick,
   input  logic clr,
   output logic sec_tick
);
   localparam logic [PRESC_W-1:0] TOP = {PRESC_W{1'b1}};

   logic [PRESC_W-1:0] cnt_q;

   if (PRESC_W < 2) begin : g_bad_width
      $error("rtc_prescaler: PRESC_W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt_q <= '0;
      else if (clr)      cnt_q <= '0;
      else if (osc_tick) cnt_q <= cnt_q + 1'b1;
   end

   assign sec_tick = osc_tick && !clr && (cnt_q == TOP);

endmodule

// File: rtl/rtc_hold_ctrl.sv
module rtc_hold_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_tick,
   input  logic hold_req,
   input  logic sec_tick,
   input  logic sec_clr,
   output logic hold_ack,
   output logic step
);
   logic ack_q;
   logic owed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q  <= 1'b0;
         owed_q <= 1'b0;
      end else begin
         if (!hold_req)     ack_q <= 1'b0;
         else if (osc_tick) ack_q <= 1'b1;

         if (sec_clr)                  owed_q <= 1'b0;
         else if (ack_q)               owed_q <= owed_q | sec_tick;
         else if (owed_q && !sec_tick) owed_q <= 1'b0;
      end
   end

   assign hold_ack = ack_q;
   assign step     = !ack_q && (sec_tick || owed_q);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_cal_pkg::*;
#(
   parameter bit LEAP_EN  = 1'b1,
   parameter int YEAR_MAX = 99
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  step,
   input  logic                  wr_en,
   input  logic [2:0]            wr_field,
   input  logic [CAL_DATA_W-1:0] wr_data,
   output logic [5:0]            sec,
   output logic [5:0]            min,
   output logic [4:0]            hour,
   output logic [4:0]            day,
   output logic [3:0]            month,
   output logic [6:0]            year,
   output logic                  min_roll
);
   localparam logic [5:0] SEC_LAST  = 6'd59;
   localparam logic [5:0] MIN_LAST  = 6'd59;
   localparam logic [4:0] HOUR_LAST = 5'd23;
   localparam logic [3:0] MON_LAST  = 4'd12;
   localparam logic [6:0] YEAR_LAST = 7'(YEAR_MAX);

   if (YEAR_MAX < 1 || YEAR_MAX > 127) begin : g_bad_year
      $error("rtc_calendar: YEAR_MAX out of range");
   end

   logic [5:0] sec_q, min_q;
   logic [4:0] hour_q, day_q;
   logic [3:0] mon_q;
   logic [6:0] year_q;
   logic       leap;
   logic [4:0] day_last;
   logic       sec_wrap, min_wrap, hour_wrap, day_wrap, mon_wrap, year_wrap;

   if (LEAP_EN) begin : g_leap
      assign leap = (year_q[1:0] == 2'b00);
   end else begin : g_no_leap
      assign leap = 1'b0;
   end

   always_comb begin
      day_last  = month_len(mon_q, leap);
      sec_wrap  = (sec_q  >= SEC_LAST);
      min_wrap  = (min_q  >= MIN_LAST);
      hour_wrap = (hour_q >= HOUR_LAST);
      day_wrap  = (day_q  >= day_last);
      mon_wrap  = (mon_q  >= MON_LAST);
      year_wrap = (year_q >= YEAR_LAST);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_q  <= '0;
         min_q  <= '0;
         hour_q <= '0;
         day_q  <= 5'd1;
         mon_q  <= 4'd1;
         year_q <= '0;
      end else if (wr_en) begin
         case (wr_field)
            FLD_SEC:   sec_q  <= wr_data[5:0];
            FLD_MIN:   min_q  <= wr_data[5:0];
            FLD_HOUR:  hour_q <= wr_data[4:0];
            FLD_DAY:   day_q  <= wr_data[4:0];
            FLD_MONTH: mon_q  <= wr_data[3:0];
            FLD_YEAR:  year_q <= wr_data[6:0];
            default:   ;
         endcase
      end else if (step) begin
         sec_q <= sec_wrap ? 6'd0 : sec_q + 6'd1;
         if (sec_wrap) begin
            min_q <= min_wrap ? 6'd0 : min_q + 6'd1;
            if (min_wrap) begin
               hour_q <= hour_wrap ? 5'd0 : hour_q + 5'd1;
               if (hour_wrap) begin
                  day_q <= day_wrap ? 5'd1 : day_q + 5'd1;
                  if (day_wrap) begin
                     mon_q <= mon_wrap ? 4'd1 : mon_q + 4'd1;
                     if (mon_wrap) begin
                        year_q <= year_wrap ? 7'd0 : year_q + 7'd1;
                     end
                  end
               end
            end
         end
      end
   end

   assign sec      = sec_q;
   assign min      = min_q;
   assign hour     = hour_q;
   assign day      = day_q;
   assign month    = mon_q;
   assign year     = year_q;
   assign min_roll = step && sec_wrap;

endmodule

// File: rtl/rtc_event_flags.sv
module rtc_event_flags (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   input  logic       min_roll,
   input  logic       per_sel,
   input  logic       alarm_evt,
   input  logic       flag_wr_en,
   input  logic [1:0] flag_wr_data,
   output logic       per_flag,
   output logic       alm_flag,
   output logic       irq
);
   logic per_q, alm_q;
   logic per_set;

   assign per_set = per_sel ? min_roll : step;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_q <= 1'b0;
         alm_q <= 1'b0;
      end else begin
         if (per_set)                              per_q <= 1'b1;
         else if (flag_wr_en && !flag_wr_data[0])  per_q <= 1'b0;

         if (alarm_evt)                            alm_q <= 1'b1;
         else if (flag_wr_en && !flag_wr_data[1])  alm_q <= 1'b0;
      end
   end

   assign per_flag = per_q;
   assign alm_flag = alm_q;
   assign irq      = per_q | alm_q;

endmodule

// File: rtl/rtc_calendar_hold.sv
module rtc_calendar_hold
   import rtc_cal_pkg::*;
#(
   parameter int PRESC_W  = 15,
   parameter bit LEAP_EN  = 1'b1,
   parameter int YEAR_MAX = 99
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  osc_tick,
   input  logic                  hold_req,
   input  logic                  wr_en,
   input  logic [2:0]            wr_field,
   input  logic [CAL_DATA_W-1:0] wr_data,
   input  logic                  flag_wr_en,
   input  logic [1:0]            flag_wr_data,
   input  logic                  per_sel,
   input  logic                  alarm_evt,
   output logic [5:0]            sec,
   output logic [5:0]            min,
   output logic [4:0]            hour,
   output logic [4:0]            day,
   output logic [3:0]            month,
   output logic [6:0]            year,
   output logic                  hold_ack,
   output logic                  per_flag,
   output logic                  alm_flag,
   output logic                  irq
);
   logic sec_tick;
   logic step;
   logic min_roll;
   logic wr_ok;
   logic sec_clr;

   // Field writes count only while the freeze is granted.
   assign wr_ok   = wr_en && hold_ack;
   assign sec_clr = wr_ok && (wr_field == FLD_SEC);

   rtc_prescaler #(.PRESC_W(PRESC_W)) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .osc_tick (osc_tick),
      .clr      (sec_clr),
      .sec_tick (sec_tick)
   );

   rtc_hold_ctrl u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .osc_tick (osc_tick),
      .hold_req (hold_req),
      .sec_tick (sec_tick),
      .sec_clr  (sec_clr),
      .hold_ack (hold_ack),
      .step     (step)
   );

   rtc_calendar #(.LEAP_EN(LEAP_EN), .YEAR_MAX(YEAR_MAX)) u_cal (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .wr_en    (wr_ok),
      .wr_field (wr_field),
      .wr_data  (wr_data),
      .sec      (sec),
      .min      (min),
      .hour     (hour),
      .day      (day),
      .month    (month),
      .year     (year),
      .min_roll (min_roll)
   );

   rtc_event_flags u_flags (
      .clk          (clk),
      .rst_n        (rst_n),
      .step         (step),
      .min_roll     (min_roll),
      .per_sel      (per_sel),
      .alarm_evt    (alarm_evt),
      .flag_wr_en   (flag_wr_en),
      .flag_wr_data (flag_wr_data),
      .per_flag     (per_flag),
      .alm_flag     (alm_flag),
      .irq          (irq)
   );

endmodule

// File: rtl/rtc_calendar_hold_chk.sv
module rtc_calendar_hold_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       hold_req,
   input logic       hold_ack,
   input logic       wr_en,
   input logic [5:0] sec,
   input logic [5:0] min,
   input logic [4:0] hour,
   input logic [4:0] day,
   input logic [3:0] month,
   input logic       per_flag,
   input logic       alm_flag,
   input logic       flag_wr_en,
   input logic       keep_per,
   input logic       keep_alm
);
   // R5
   ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_req |=> !hold_ack);

   // R5
   frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_ack && !wr_en) |=> ($stable(sec) && $stable(min) && $stable(hour)));

   // R3
   clock_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_ack || $past(hold_ack)) || (sec <= 6'd59 && min <= 6'd59 && hour <= 5'd23));

   // R4
   date_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_ack || $past(hold_ack)) || (day >= 5'd1 && month >= 4'd1 && month <= 4'd12));

   // R9
   per_on_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(per_flag) |-> !$stable(sec));

   // R10
   per_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr_en && keep_per && per_flag) |=> per_flag);

   // R10
   alm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr_en && keep_alm && alm_flag) |=> alm_flag);

endmodule

bind rtc_calendar_hold rtc_calendar_hold_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hold_req   (hold_req),
   .hold_ack   (hold_ack),
   .wr_en      (wr_en),
   .sec        (sec),
   .min        (min),
   .hour       (hour),
   .day        (day),
   .month      (month),
   .per_flag   (per_flag),
   .alm_flag   (alm_flag),
   .flag_wr_en (flag_wr_en),
   .keep_per   (flag_wr_data[0]),
   .keep_alm   (flag_wr_data[1])
);

// File: tb/rtc_calendar_hold_test.sv
module rtc_calendar_hold_test;
   localparam int CLK_PERIOD = 10;
   localparam int PW   = 2;
   localparam int PDIV = 1 << PW;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_tick = 1'b0, hold_req = 1'b0, wr_en = 1'b0;
   logic [2:0] wr_field = '0;
   logic [6:0] wr_data = '0;
   logic       flag_wr_en = 1'b0;
   logic [1:0] flag_wr_data = '0;
   logic       per_sel = 1'b0, alarm_evt = 1'b0;
   logic [5:0] sec, min;
   logic [4:0] hour, day;
   logic [3:0] month;
   logic [6:0] year;
   logic       hold_ack, per_flag, alm_flag, irq;

   rtc_calendar_hold #(.PRESC_W(PW)) uut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   int vecs = 0, bad = 0, cyc = 0;
   bit done = 1'b0;

   // bench-side expectation
   int m_sec, m_min, m_hour, m_day, m_mon, m_year, m_p;
   bit m_ack, m_owed, m_per, m_alm, m_req, m_psel;

   function automatic int mlen(int mo, int yr);
      if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   task automatic advance();
      bit rolled = (m_sec == 59);
      m_sec = (m_sec + 1) % 60;
      if (rolled) begin
         m_min = (m_min + 1) % 60;
         if (m_min == 0) begin
            m_hour = (m_hour + 1) % 24;
            if (m_hour == 0) begin
               if (m_day >= mlen(m_mon, m_year)) begin
                  m_day = 1;
                  if (m_mon == 12) begin
                     m_mon = 1;
                     m_year = (m_year == 99) ? 0 : m_year + 1;
                  end else m_mon = m_mon + 1;
               end else m_day = m_day + 1;
            end
         end
      end
      if (!m_psel || rolled) m_per = 1'b1;
   endtask

   task automatic check(string req);
      logic [36:0] act, exp_v;
      act = {sec, min, hour, day, month, year, hold_ack, per_flag, alm_flag, irq};
      exp_v = {6'(m_sec), 6'(m_min), 5'(m_hour), 5'(m_day), 4'(m_mon), 7'(m_year),
               m_ack, m_per, m_alm, (m_per | m_alm)};
      vecs++;
      if (act !== exp_v) begin
         bad++;
         $display("FAIL %s: actual %0d:%0d:%0d d%0d m%0d y%0d ack%0b p%0b a%0b i%0b expected %0d:%0d:%0d d%0d m%0d y%0d ack%0b p%0b a%0b i%0b",
                  req, sec, min, hour, day, month, year, hold_ack, per_flag, alm_flag, irq,
                  m_sec, m_min, m_hour, m_day, m_mon, m_year, m_ack, m_per, m_alm, m_per | m_alm);
      end
   endtask

   task automatic osc_pulse(string req);
      bit wrap;
      @(negedge clk) osc_tick = 1'b1;
      @(negedge clk) osc_tick = 1'b0;
      wrap = (m_p == PDIV - 1);
      m_p = (m_p + 1) % PDIV;
      if (wrap) begin
         if (m_ack) m_owed = 1'b1;
         else advance();
      end
      if (m_req) m_ack = 1'b1;
      check(req);
   endtask

   task automatic do_hold();
      @(negedge clk) hold_req = 1'b1;
      m_req = 1'b1;
      @(negedge clk);
      check("R5 ack low before osc tick");
      osc_pulse("R5 ack after first osc tick");
   endtask

   task automatic do_release(string req);
      @(negedge clk) hold_req = 1'b0;
      m_req = 1'b0;
      @(negedge clk);
      m_ack = 1'b0;
      @(negedge clk);
      if (m_owed) begin
         advance();
         m_owed = 1'b0;
      end
      check(req);
   endtask

   task automatic wr(input int fld, input int val, string req);
      @(negedge clk) begin wr_en = 1'b1; wr_field = 3'(fld); wr_data = 7'(val); end
      @(negedge clk) wr_en = 1'b0;
      if (m_ack) begin
         case (fld)
            0: begin m_sec = val; m_p = 0; m_owed = 1'b0; end
            1: m_min = val;
            2: m_hour = val;
            3: m_day = val;
            4: m_mon = val;
            5: m_year = val;
            default: ;
         endcase
      end
      check(req);
   endtask

   task automatic flag_wr(input logic [1:0] d, string req);
      @(negedge clk) begin flag_wr_en = 1'b1; flag_wr_data = d; end
      @(negedge clk) flag_wr_en = 1'b0;
      if (!d[0]) m_per = 1'b0;
      if (!d[1]) m_alm = 1'b0;
      check(req);
   endtask

   task automatic alarm(string req);
      @(negedge clk) alarm_evt = 1'b1;
      @(negedge clk) alarm_evt = 1'b0;
      m_alm = 1'b1;
      check(req);
   endtask

   task automatic set_time(int y, int mo, int d, int h, int mi, int s);
      do_hold();
      wr(5, y, "R6 year write");
      wr(4, mo, "R6 month write");
      wr(3, d, "R6 day write");
      wr(2, h, "R6 hour write");
      wr(1, mi, "R6 minute write");
      wr(0, s, "R8 second write");
      do_release("R7 release without owed second");
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         bad++;
         $display("FAIL watchdog: actual still running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
         $finish;
      end
   end

   initial begin
      int yrs[5] = '{0, 1, 3, 4, 99};
      m_sec = 0; m_min = 0; m_hour = 0; m_day = 1; m_mon = 1; m_year = 0; m_p = 0;
      m_ack = 0; m_owed = 0; m_per = 0; m_alm = 0; m_req = 0; m_psel = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset state");

      // R2 / R3: free run across a minute roll, per-second periodic
      for (int i = 0; i < PDIV * 62; i++) osc_pulse("R2 R3 free run");
      flag_wr(2'b00, "R10 clear both");

      // R6: writes ignored when not frozen, bad field code ignored when frozen
      wr(1, 33, "R6 write ignored without freeze");
      do_hold();
      wr(7, 5, "R6 undefined field code ignored");
      wr(6, 5, "R6 undefined field code ignored");

      // R5 / R7: wraps during freeze, one replayed advance
      for (int i = 0; i < PDIV * 3; i++) osc_pulse("R5 frozen while prescaler runs");
      do_release("R7 single owed advance on release");
      check("R9 periodic set by replayed advance");

      // R8: seconds write forgives owed advance and restarts prescaler
      do_hold();
      for (int i = 0; i < PDIV; i++) osc_pulse("R5 frozen");
      wr(0, 10, "R8 seconds write in freeze");
      do_release("R8 no owed advance after seconds write");
      for (int i = 0; i < PDIV; i++) osc_pulse("R8 prescaler restarted at 0");

      // R3 / R4: month ends across years, full roll from 23:59:59
      foreach (yrs[k]) begin
         for (int mo = 1; mo <= 12; mo++) begin
            set_time(yrs[k], mo, mlen(mo, yrs[k]), 23, 59, 59);
            for (int i = 0; i < PDIV; i++) osc_pulse("R3 R4 month end roll");
         end
      end
      set_time(4, 2, 28, 23, 59, 59);
      for (int i = 0; i < PDIV; i++) osc_pulse("R4 leap Feb 28 to 29");
      set_time(99, 12, 31, 23, 59, 59);
      for (int i = 0; i < PDIV; i++) osc_pulse("R3 year 99 to 0");

      // R9 / R10 / R11: flags and shared interrupt
      flag_wr(2'b00, "R10 clear both flags");
      m_psel = 1'b1;
      @(negedge clk) per_sel = 1'b1;
      set_time(5, 6, 7, 8, 9, 57);
      check("R9 writes never set periodic flag");
      for (int i = 0; i < PDIV * 2; i++) osc_pulse("R9 minute mode, no roll");
      for (int i = 0; i < PDIV; i++) osc_pulse("R9 minute mode, roll sets flag");
      alarm("R10 alarm sets flag, R11 irq");
      flag_wr(2'b11, "R10 ones keep both flags");
      flag_wr(2'b10, "R10 clear periodic keep alarm, R11 irq from alarm");
      flag_wr(2'b11, "R10 ones keep alarm");
      flag_wr(2'b01, "R10 clear alarm, R11 irq low");
      m_psel = 1'b0;
      @(negedge clk) per_sel = 1'b0;
      for (int i = 0; i < PDIV; i++) osc_pulse("R9 R11 second mode sets flag");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end
endmodule